// File: doc/BRIEF.md
# Multiplexed-Bus Nibble Register Interface

This block is the processor-facing port of a small peripheral that holds sixteen 4-bit registers. A 4-bit address picks a register. A 4-bit data bus, split here into input, output and output-enable, carries the value in either direction. Two chip selects qualify every access. `cs1` is active high and is meant to come from a supply monitor: when it drops, the block goes to standby and two control bits are forced to zero. `cs0_n` is the ordinary active-low select. The `rd_n` and `wr_n` strobes are active low.

On a processor whose address and data share pins, the `ale` input captures the address and `cs0_n`. While `ale` is high both pass straight through. When `ale` falls they are frozen, and they stay frozen until `ale` rises again. On a bus that is not multiplexed, `ale` is simply tied high.

Writes take effect on the trailing (rising) edge of `wr_n`. The strobes are brought into the internal clock domain through a two-stage synchronizer followed by an edge detector. A separate open-drain pulse output follows an external tick whenever its enable bit is set. The chip selects never gate this output.

Top module: `nibble_bus_if`

## Requirements
- R1: While `rst` is high and right after it, `d_oe` is 0, `pulse_n` is 1 and `err_overlap` is 0, and every one of the sixteen registers reads as 0.
- R2: When the block is selected (`cs1`=1 and the effective `cs0_n`=0) with `rd_n`=0 and `wr_n`=1, `d_oe` is 1 and `d_out` shows the register at the effective address, with no clock delay.
- R3: A rising edge of `wr_n` while selected with `rd_n`=1 stores the `d_in` value present before the edge into the register at the effective address. The store is visible no more than three clock edges after the strobe rises.
- R4: When `rd_n` and `wr_n` are both 0 while selected, `d_oe` is 0. A `wr_n` release that happens while `rd_n` is still low stores nothing. Such an overlap sets `err_overlap`, which then stays at 1 until reset.
- R5: When `cs1`=0, or when the effective `cs0_n`=1, `d_oe` is 0 and a write strobe leaves every register unchanged.
- R6: While `ale`=1, the effective address and `cs0_n` equal the live `addr` and `cs0_n` pins.
- R7: While `ale`=0, the effective address and `cs0_n` keep the values sampled at the last clock edge on which `ale` was 1, whatever the pins do.
- R8: When `cs1` falls, bit 0 (hold) and bit 1 (reset) of register 0xD are cleared at once, with no clock needed. They stay clear while `cs1` is low. Bits 3:2 of that register keep their values.
- R9: When bit 0 of register 0xE is 0, `pulse_n` is 1 from the next clock edge on. When that bit is 1, each clock edge that sees `tick`=1 inverts `pulse_n`. Neither chip select affects this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| cs1 | input | 1 | Supply-good select, active high; low means standby |
| cs0_n | input | 1 | Chip select, active low, captured by `ale` |
| ale | input | 1 | Address latch enable; high is transparent |
| addr | input | 4 | Register address, captured by `ale` |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; the write happens on its rising edge |
| d_in | input | 4 | Data bus, inbound half |
| d_out | output | 4 | Data bus, outbound half |
| d_oe | output | 1 | Data bus drive enable |
| tick | input | 1 | Periodic tick, one clock wide |
| pulse_n | output | 1 | Open-drain pulse; 0 pulls the line low |
| err_overlap | output | 1 | Sticky flag for a read and write strobe overlap |

## Verification
The first pattern writes every address with a distinct value and reads each one back. An address decode or data path fault then shows up as a wrong value at a known location. The strobes are also tried in less usual orders: a write with `cs0_n` high, a write with `cs1` low, and a read–write overlap that is released write-first. Each of these must leave the registers unchanged, which separates a correct qualification from a store that ignores the selects. A multiplexed sequence moves `addr` and `cs0_n` after `ale` falls, which separates a held latch from a transparent one. Finally, ticks delivered while `cs1` is low show that the pulse output runs on its own, independent of the selects.

// File: rtl/nbif_pkg.sv
package nbif_pkg;

    localparam int NB_DW = 4;
    localparam int NB_AW = 4;

    typedef enum logic [1:0] {
        BM_IDLE  = 2'd0,
        BM_READ  = 2'd1,
        BM_WRITE = 2'd2,
        BM_CLASH = 2'd3
    } bus_mode_e;

    typedef struct packed {
        logic             rd_n;
        logic             wr_n;
        logic             sel;
        logic [NB_AW-1:0] addr;
        logic [NB_DW-1:0] data;
    } bus_smp_t;

    localparam bus_smp_t BUS_QUIET = '{rd_n: 1'b1, wr_n: 1'b1, sel: 1'b0,
                                       addr: '0, data: '0};

    function automatic bus_mode_e decode_mode(input logic sel,
                                              input logic rd_n,
                                              input logic wr_n);
        if (!sel)
            return BM_IDLE;
        case ({rd_n, wr_n})
            2'b01:   return BM_READ;
            2'b10:   return BM_WRITE;
            2'b00:   return BM_CLASH;
            default: return BM_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/nbif_front.sv
module nbif_front
    import nbif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs1,
    input  logic             cs0_n,
    input  logic             ale,
    input  logic [NB_AW-1:0] addr,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [NB_DW-1:0] d_in,
    output bus_mode_e        mode,
    output logic [NB_AW-1:0] eff_addr,
    output logic             wr_req,
    output logic [NB_AW-1:0] wr_addr,
    output logic [NB_DW-1:0] wr_data,
    output logic             clash
);

    localparam int LAST = SYNC_STAGES;

    logic [NB_AW-1:0] held_addr;
    logic             held_cs0_n;
    logic             eff_cs0_n;
    logic             sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_addr  <= '0;
            held_cs0_n <= 1'b1;
        end else if (ale) begin
            held_addr  <= addr;
            held_cs0_n <= cs0_n;
        end
    end

    assign eff_addr  = ale ? addr  : held_addr;
    assign eff_cs0_n = ale ? cs0_n : held_cs0_n;
    assign sel       = cs1 & ~eff_cs0_n;
    assign mode      = decode_mode(sel, rd_n, wr_n);

    bus_smp_t pipe [0:LAST];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= BUS_QUIET;
        else     pipe[0] <= '{rd_n: rd_n, wr_n: wr_n, sel: sel,
                              addr: eff_addr, data: d_in};
    end

    for (genvar g = 1; g <= LAST; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[g] <= BUS_QUIET;
            else     pipe[g] <= pipe[g-1];
        end
    end

    assign wr_req  = pipe[LAST-1].wr_n & ~pipe[LAST].wr_n &
                     pipe[LAST].sel & pipe[LAST].rd_n;
    assign wr_addr = pipe[LAST].addr;
    assign wr_data = pipe[LAST].data;
    assign clash   = decode_mode(pipe[LAST].sel, pipe[LAST].rd_n,
                                 pipe[LAST].wr_n) == BM_CLASH;

endmodule

// File: rtl/nbif_regfile.sv
module nbif_regfile
    import nbif_pkg::*;
#(
    parameter int CTL_ADDR   = 13,
    parameter int HOLD_BIT   = 0,
    parameter int RST_BIT    = 1,
    parameter int PULSE_ADDR = 14,
    parameter int PEN_BIT    = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs1,
    input  logic             wr_req,
    input  logic [NB_AW-1:0] wr_addr,
    input  logic [NB_DW-1:0] wr_data,
    input  logic [NB_AW-1:0] rd_addr,
    output logic [NB_DW-1:0] rd_data,
    output logic             pulse_en,
    output logic [1:0]       ctl_lo
);

    localparam int DEPTH = 1 << NB_AW;

    logic [DEPTH*NB_DW-1:0] bits;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [NB_AW-1:0] IDX = i[NB_AW-1:0];
        logic hit;
        assign hit = wr_req && (wr_addr == IDX);
        for (genvar b = 0; b < NB_DW; b++) begin : g_bit
            logic q;
            if (i == CTL_ADDR && (b == HOLD_BIT || b == RST_BIT)) begin : g_stby
                always_ff @(posedge clk or negedge cs1) begin
                    if (!cs1)     q <= 1'b0;
                    else if (rst) q <= 1'b0;
                    else if (hit) q <= wr_data[b];
                end
            end else begin : g_plain
                always_ff @(posedge clk) begin
                    if (rst)      q <= 1'b0;
                    else if (hit) q <= wr_data[b];
                end
            end
            assign bits[i*NB_DW + b] = q;
        end
    end

    assign rd_data  = bits[rd_addr*NB_DW +: NB_DW];
    assign pulse_en = bits[PULSE_ADDR*NB_DW + PEN_BIT];
    assign ctl_lo   = {bits[CTL_ADDR*NB_DW + RST_BIT], bits[CTL_ADDR*NB_DW + HOLD_BIT]};

endmodule

// File: rtl/nbif_pulse.sv
module nbif_pulse (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en,
    output logic pulse_n
);

    always_ff @(posedge clk) begin
        if (rst)       pulse_n <= 1'b1;
        else if (!en)  pulse_n <= 1'b1;
        else if (tick) pulse_n <= ~pulse_n;
    end

endmodule

// File: rtl/nibble_bus_if.sv
module nibble_bus_if
    import nbif_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CTL_ADDR    = 13,
    parameter int HOLD_BIT    = 0,
    parameter int RST_BIT     = 1,
    parameter int PULSE_ADDR  = 14,
    parameter int PEN_BIT     = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs1,
    input  logic             cs0_n,
    input  logic             ale,
    input  logic [NB_AW-1:0] addr,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [NB_DW-1:0] d_in,
    output logic [NB_DW-1:0] d_out,
    output logic             d_oe,
    input  logic             tick,
    output logic             pulse_n,
    output logic             err_overlap
);

    bus_mode_e        mode;
    logic [NB_AW-1:0] eff_addr;
    logic             wr_req;
    logic [NB_AW-1:0] wr_addr;
    logic [NB_DW-1:0] wr_data;
    logic             clash;
    logic [NB_DW-1:0] rd_data;
    logic             pulse_en;
    logic [1:0]       ctl_lo;

    nbif_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst(rst), .cs1(cs1), .cs0_n(cs0_n), .ale(ale),
        .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .d_in(d_in),
        .mode(mode), .eff_addr(eff_addr), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .clash(clash)
    );

    nbif_regfile #(
        .CTL_ADDR(CTL_ADDR), .HOLD_BIT(HOLD_BIT), .RST_BIT(RST_BIT),
        .PULSE_ADDR(PULSE_ADDR), .PEN_BIT(PEN_BIT)
    ) u_regs (
        .clk(clk), .rst(rst), .cs1(cs1), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(eff_addr),
        .rd_data(rd_data), .pulse_en(pulse_en), .ctl_lo(ctl_lo)
    );

    nbif_pulse u_pulse (
        .clk(clk), .rst(rst), .tick(tick), .en(pulse_en), .pulse_n(pulse_n)
    );

    assign d_oe  = (mode == BM_READ);
    assign d_out = d_oe ? rd_data : '0;

    always_ff @(posedge clk) begin
        if (rst)        err_overlap <= 1'b0;
        else if (clash) err_overlap <= 1'b1;
    end

endmodule

// File: rtl/nbif_chk.sv
module nbif_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs1,
    input logic       rd_n,
    input logic       wr_n,
    input logic       d_oe,
    input logic       pulse_n,
    input logic       err_overlap,
    input logic       pulse_en,
    input logic [1:0] ctl_lo
);

    // R4
    no_clash_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !wr_n) |-> !d_oe);

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_overlap |=> err_overlap);

    // R5
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cs1 |-> !d_oe);

    // R8
    standby_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !cs1 |-> (ctl_lo == 2'b00));

    // R9
    pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pulse_en |=> pulse_n);

endmodule

bind nibble_bus_if nbif_chk u_chk (
    .clk(clk), .rst(rst), .cs1(cs1), .rd_n(rd_n), .wr_n(wr_n),
    .d_oe(d_oe), .pulse_n(pulse_n), .err_overlap(err_overlap),
    .pulse_en(pulse_en), .ctl_lo(ctl_lo)
);

// File: tb/nibble_bus_if_bench.sv
module nibble_bus_if_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs1 = 1'b1;
    logic       cs0_n = 1'b0;
    logic       ale = 1'b1;
    logic [3:0] addr = '0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [3:0] d_in = '0;
    logic [3:0] d_out;
    logic       d_oe;
    logic       tick = 1'b0;
    logic       pulse_n;
    logic       err_overlap;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;
    bit  live_cmp = 1'b0;

    logic [3:0] mem_m [16];
    logic [3:0] held_a;
    logic       held_c;
    logic       p_m;

    always #4 clk = ~clk;

    nibble_bus_if u_nibble_bus_if (
        .clk(clk), .rst(rst), .cs1(cs1), .cs0_n(cs0_n), .ale(ale),
        .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .d_in(d_in),
        .d_out(d_out), .d_oe(d_oe), .tick(tick), .pulse_n(pulse_n),
        .err_overlap(err_overlap)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] m_addr();
        return ale ? addr : held_a;
    endfunction

    function automatic logic m_sel();
        return cs1 && !(ale ? cs0_n : held_c);
    endfunction

    // reference model state, advanced on each edge
    always @(posedge clk) begin
        if (rst) begin
            held_a = '0;
            held_c = 1'b1;
            p_m    = 1'b1;
            for (int i = 0; i < 16; i++) mem_m[i] = '0;
        end else begin
            if (!mem_m[14][0]) p_m = 1'b1;
            else if (tick)     p_m = ~p_m;
            if (ale) begin
                held_a = addr;
                held_c = cs0_n;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live_cmp && !done) begin
            logic exp_oe;
            exp_oe = m_sel() && !rd_n && wr_n;
            chk("R2/R4/R5 d_oe", {7'd0, d_oe}, {7'd0, exp_oe});
            if (exp_oe) chk("R2 d_out", {4'd0, d_out}, {4'd0, mem_m[m_addr()]});
            chk("R9 pulse_n", {7'd0, pulse_n}, {7'd0, p_m});
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [3:0] d);
        logic       s;
        logic [3:0] wa;
        @(posedge clk); #1;
        addr = a; d_in = d; wr_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        s  = m_sel() && rd_n;
        wa = m_addr();
        wr_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        if (s) mem_m[wa] = d;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [3:0] exp, input string tag);
        @(posedge clk); #1;
        addr = a; rd_n = 1'b0;
        @(negedge clk);
        chk({tag, " oe"}, {7'd0, d_oe}, 8'd1);
        chk({tag, " data"}, {4'd0, d_out}, {4'd0, exp});
        @(posedge clk); #1;
        rd_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1 tick = 1'b1;
            @(posedge clk); #1 tick = 1'b0;
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 d_oe in reset", {7'd0, d_oe}, 8'd0);
        chk("R1 pulse_n in reset", {7'd0, pulse_n}, 8'd1);
        chk("R1 err in reset", {7'd0, err_overlap}, 8'd0);
        @(posedge clk); #1 rst = 1'b0;
        live_cmp = 1'b1;
        for (int i = 0; i < 16; i++) bus_read(i[3:0], 4'h0, "R1 reset contents");

        // R3: fill all addresses, read back (R2)
        for (int i = 0; i < 16; i++) bus_write(i[3:0], 4'((i * 7 + 3) & 15));
        for (int i = 0; i < 16; i++) bus_read(i[3:0], 4'((i * 7 + 3) & 15), "R3 write/readback");

        // R5: unselected write and read
        @(posedge clk); #1 cs0_n = 1'b1;
        bus_write(4'd2, 4'h0);
        @(posedge clk); #1 addr = 4'd2; rd_n = 1'b0;
        @(negedge clk);
        chk("R5 no drive when cs0_n high", {7'd0, d_oe}, 8'd0);
        @(posedge clk); #1 rd_n = 1'b1; cs0_n = 1'b0;
        bus_read(4'd2, 4'h1, "R5 unselected write ignored");

        // R4: strobe overlap, write released first
        chk("R4 err clear before overlap", {7'd0, err_overlap}, 8'd0);
        @(posedge clk); #1 addr = 4'd3; d_in = 4'hF; rd_n = 1'b0;
        @(posedge clk); #1 wr_n = 1'b0;
        @(negedge clk);
        chk("R4 no drive on overlap", {7'd0, d_oe}, 8'd0);
        repeat (2) @(posedge clk);
        #1 wr_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 rd_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R4 err set", {7'd0, err_overlap}, 8'd1);
        bus_read(4'd3, 4'((3 * 7 + 3) & 15), "R4 overlap stored nothing");
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R4 err sticky", {7'd0, err_overlap}, 8'd1);

        // R6/R7: multiplexed address capture
        @(posedge clk); #1 ale = 1'b1; addr = 4'd5; cs0_n = 1'b0;
        @(posedge clk); #1 ale = 1'b0; addr = 4'd9; cs0_n = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        chk("R7 held select", {7'd0, d_oe}, 8'd1);
        chk("R7 held address", {4'd0, d_out}, {4'd0, 4'((5 * 7 + 3) & 15)});
        @(posedge clk); #1 ale = 1'b1;
        @(negedge clk);
        chk("R6 transparent cs0_n", {7'd0, d_oe}, 8'd0);
        @(posedge clk); #1 cs0_n = 1'b0; addr = 4'd6;
        @(negedge clk);
        chk("R6 transparent address", {4'd0, d_out}, {4'd0, 4'((6 * 7 + 3) & 15)});
        @(posedge clk); #1 rd_n = 1'b1;

        // R8: standby clear of control bits
        bus_write(4'd13, 4'hF);
        @(posedge clk); #1 cs1 = 1'b0; mem_m[13][1:0] = 2'b00;
        rd_n = 1'b0; addr = 4'd13;
        @(negedge clk);
        chk("R5 standby no drive", {7'd0, d_oe}, 8'd0);
        @(posedge clk); #1 rd_n = 1'b1;
        bus_write(4'd13, 4'hF);
        @(posedge clk); #1 cs1 = 1'b1;
        bus_read(4'd13, 4'hC, "R8 control bits cleared");

        // R9: pulse runs with selects inactive
        bus_write(4'd14, 4'h1);
        @(posedge clk); #1 cs1 = 1'b0; mem_m[13][1:0] = 2'b00; cs0_n = 1'b1;
        ticks(7);
        @(negedge clk);
        chk("R9 pulse after seven ticks", {7'd0, pulse_n}, 8'd0);
        @(posedge clk); #1 cs1 = 1'b1; cs0_n = 1'b0;
        bus_write(4'd14, 4'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 pulse released when disabled", {7'd0, pulse_n}, 8'd1);
        ticks(2);
        @(negedge clk);
        chk("R9 ticks ignored when disabled", {7'd0, pulse_n}, 8'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule